// File: doc/BRIEF.md
# Load Data Size and Sign Formatter

This block sits between a memory read path and the register write port of a 64-bit integer core. It takes up to eight raw bytes as they arrive from memory, lowest address first, and turns them into the 64-bit value that the destination register receives. The access size is 1, 2, 4 or 8 bytes. A sign flag selects an algebraic load instead of a zero-extending one. A reverse flag selects a byte-reversed load. The value follows most-significant-bit-first numbering: in a normal load, the byte at the lowest address becomes the most significant byte of the loaded field.

One datapath serves every load variant. Lane multiplexers first place the selected bytes, in normal or reversed order, right-aligned in the word. An extension stage then fills the unused upper lanes with zeros or with copies of the sign bit. The result is registered, so it appears one cycle after the input strobe. Asking for sign extension and byte reversal together is not a legal combination: the block raises an error flag and returns zero.

Top module: `ldfmt_top`

## Requirements
- R1: After reset, `out_valid`, `out_err` and `out_data` are all zero.
- R2: `out_valid` is high exactly one cycle after `in_valid` is high. `out_data` and `out_err` in that cycle reflect the inputs sampled with that strobe. Back-to-back strobes give back-to-back results.
- R3: Size code 0 (1 byte) places raw byte 0 (`in_data[7:0]`) in `out_data[7:0]` and clears bits 63:8 when sign extension is off. Byte reversal has no effect at this size.
- R4: Size codes 1 (2 bytes) and 2 (4 bytes), with both flags clear, give the bytes big-endian: raw byte 0 is the most significant byte of the field. Every bit above the field is zero.
- R5: With `in_sext` set and `in_brev` clear, sizes 1, 2 and 4 bytes fill every bit above the field with the field's most significant bit.
- R6: Size code 1 with `in_brev` set gives raw byte 0 in bits 7:0 and raw byte 1 in bits 15:8, with bits 63:16 clear.
- R7: Size code 2 with `in_brev` set places raw byte k in bits 8k+7:8k for k = 0..3, with bits 63:32 clear.
- R8: Size code 3 (8 bytes) gives raw byte 0 in bits 63:56 down to raw byte 7 in bits 7:0. With `in_brev` set, raw byte k lands in bits 8k+7:8k.
- R9: For size code 3, `in_sext` alone has no effect on `out_data`.
- R10: When `in_sext` and `in_brev` are both set, at any size, `out_err` is 1 and `out_data` is zero. Otherwise `out_err` is 0.
- R11: In a cycle where `in_valid` is low, `out_data` and `out_err` keep their previous values.
- R12: Raw bytes at or above the access size have no effect on `out_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Raw data and controls are valid this cycle |
| in_data | input | 64 | Raw bytes, byte k (address offset k) in bits 8k+7:8k |
| in_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| in_sext | input | 1 | Sign-extend the loaded field |
| in_brev | input | 1 | Byte-reversed load |
| out_valid | output | 1 | Formatted result valid |
| out_data | output | 64 | Value for the destination register |
| out_err | output | 1 | Illegal flag combination was requested |

## Verification
The bench tries all sixteen combinations of size and flags on several data patterns. It pays most attention to sign bits that sit just inside or just outside the field. A wrong sign tap would smear the wrong bit across the upper lanes or fill a positive value with ones. The bench fills the bytes above the access size with noise, so a lane multiplexer that picks the wrong byte index or leaves a dead lane open shows up as stray upper bits. Reversed halfwords and words are checked against a byte-swapping model, which catches an order that was reversed across the full 8 bytes instead of only within the access size. The bench also checks an error request at size 8, back-to-back strobes, and idle cycles where the outputs must hold.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int unsigned LD_BYTES = 8;
  localparam int unsigned LD_WIDTH = LD_BYTES * 8;
  localparam int unsigned LEN_W    = $clog2(LD_BYTES) + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ld_size_e;

  // number of live byte lanes for a size code
  function automatic logic [LEN_W-1:0] lane_count(input logic [1:0] code);
    return LEN_W'(1) << code;
  endfunction

  // source lane feeding result lane j (result lane 0 = least significant)
  function automatic int unsigned src_lane(input int unsigned j,
                                           input logic [LEN_W-1:0] n,
                                           input logic rev);
    int unsigned nn;
    nn = int'(n);
    if (rev) return j;
    return nn - 1 - j;
  endfunction
endpackage

// File: rtl/ldfmt_gather.sv
module ldfmt_gather
  import ldfmt_pkg::*;
#(
  parameter int unsigned NBYTES = LD_BYTES
) (
  input  logic [8*NBYTES-1:0] raw,
  input  logic [1:0]          size,
  input  logic                rev,
  output logic [8*NBYTES-1:0] packed_o,
  output logic [NBYTES-1:0]   lane_live
);
  localparam int unsigned DW = 8 * NBYTES;

  logic [LEN_W-1:0] nlen;
  assign nlen = lane_count(size);

  for (genvar j = 0; j < NBYTES; j++) begin : g_lane
    int unsigned src;
    assign lane_live[j] = (j < int'(nlen));
    always_comb begin
      src = src_lane(j, nlen, rev) % NBYTES;
      packed_o[8*j +: 8] = lane_live[j] ? raw[8*src +: 8] : 8'h00;
    end
  end

  // live lanes always form a contiguous run from lane 0 (R12)
  always_comb begin
    if (nlen != '0)
      assert_live_run_R12: assert (lane_live[0] && ((lane_live & (lane_live + 1'b1)) == '0));
  end

  logic unused_w;
  assign unused_w = ^DW;
endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend
  import ldfmt_pkg::*;
#(
  parameter int unsigned NBYTES = LD_BYTES
) (
  input  logic [8*NBYTES-1:0] packed_i,
  input  logic [NBYTES-1:0]   lane_live,
  input  logic                sext,
  output logic                sign_bit,
  output logic [8*NBYTES-1:0] ext_o
);
  // sign bit = top bit of the highest live lane
  always_comb begin
    sign_bit = 1'b0;
    for (int j = 0; j < NBYTES; j++) begin
      if (lane_live[j]) sign_bit = packed_i[8*j+7];
    end
  end

  logic fill;
  assign fill = sext & sign_bit;

  for (genvar j = 0; j < NBYTES; j++) begin : g_fill
    assign ext_o[8*j +: 8] = lane_live[j] ? packed_i[8*j +: 8] : {8{fill}};
  end

  // without sign extension every dead lane must read as zero (R4)
  always_comb begin
    for (int j = 0; j < NBYTES; j++) begin
      if (!sext && !lane_live[j])
        assert_zero_fill_R4: assert (ext_o[8*j +: 8] == 8'h00);
    end
  end
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
  import ldfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LD_WIDTH-1:0] in_data,
  input  logic [1:0]          in_size,
  input  logic                in_sext,
  input  logic                in_brev,
  output logic                out_valid,
  output logic [LD_WIDTH-1:0] out_data,
  output logic                out_err
);
  logic [LD_WIDTH-1:0] gathered;
  logic [LD_BYTES-1:0] live;
  logic [LD_WIDTH-1:0] extended;
  logic                sign_tap;
  logic                bad_combo;

  ldfmt_gather #(.NBYTES(LD_BYTES)) u_gather (
    .raw       (in_data),
    .size      (in_size),
    .rev       (in_brev),
    .packed_o  (gathered),
    .lane_live (live)
  );

  ldfmt_extend #(.NBYTES(LD_BYTES)) u_extend (
    .packed_i  (gathered),
    .lane_live (live),
    .sext      (in_sext),
    .sign_bit  (sign_tap),
    .ext_o     (extended)
  );

  assign bad_combo = in_sext & in_brev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err  <= bad_combo;
        out_data <= bad_combo ? '0 : extended;
      end
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_err_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_err == $past(in_sext && in_brev)));
  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == '0));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_err)));
  assert_half_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sext && in_size == SZ_HALF) |=> (out_data[63:16] == '0));
  assert_byte_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sext && in_size == SZ_BYTE) |=> (out_data == {56'd0, $past(in_data[7:0])}));
  assert_dbl_nosign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == SZ_DBL && in_sext && !in_brev) |=>
      (out_data == {$past(in_data[7:0]), $past(in_data[15:8]), $past(in_data[23:16]),
                    $past(in_data[31:24]), $past(in_data[39:32]), $past(in_data[47:40]),
                    $past(in_data[55:48]), $past(in_data[63:56])}));
  assert_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sext && !in_brev && in_size == SZ_WORD) |=>
      (out_data[63:32] == {32{$past(in_data[7])}}));
endmodule

// File: tb/tb_ldfmt_top.sv
`timescale 1ns/1ps
module tb_ldfmt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [1:0]  in_size = '0;
  logic        in_sext = 1'b0;
  logic        in_brev = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_err;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ldfmt_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_size(in_size), .in_sext(in_sext), .in_brev(in_brev),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  // independent model: shift bytes in one by one
  function automatic logic [63:0] model(input logic [63:0] raw, input logic [1:0] sz,
                                        input logic sx, input logic br);
    int n;
    logic [63:0] v;
    n = 1 << sz;
    v = '0;
    if (sx && br) return '0;
    if (br) begin
      for (int k = n - 1; k >= 0; k--) v = (v << 8) | 64'(raw[8*k +: 8]);
    end else begin
      for (int k = 0; k < n; k++) v = (v << 8) | 64'(raw[8*k +: 8]);
    end
    if (sx && n < 8 && v[8*n-1]) v = v | ~((64'd1 << (8*n)) - 64'd1);
    return v;
  endfunction

  function automatic string tag_of(input logic [1:0] sz, input logic sx, input logic br);
    if (sx && br) return "R10";
    if (sz == 2'd3) return sx ? "R9" : "R8";
    if (br) return (sz == 2'd1) ? "R6" : (sz == 2'd2) ? "R7" : "R3";
    if (sx) return "R5";
    return (sz == 2'd0) ? "R3" : "R4";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] d, input logic [1:0] sz, input logic sx, input logic br);
    in_valid = 1'b1; in_data = d; in_size = sz; in_sext = sx; in_brev = br;
  endtask

  // one load: drive at negedge, result sampled at the following negedge
  task automatic one_load(input logic [63:0] d, input logic [1:0] sz, input logic sx, input logic br);
    @(negedge clk);
    drive(d, sz, sx, br);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {63'd0, out_valid}, 64'd1);
    check(tag_of(sz, sx, br), out_data, model(d, sz, sx, br));
    check("R10", {63'd0, out_err}, {63'd0, sx & br});
  endtask

  task automatic t_reset;
    check("R1", {62'd0, out_valid, out_err}, 64'd0);
    check("R1", out_data, 64'd0);
  endtask

  task automatic t_all_modes;
    logic [63:0] pats [4];
    pats[0] = 64'h8877_6655_4433_2211;
    pats[1] = 64'h0123_4567_89AB_CDEF;
    pats[2] = 64'hF00F_7E81_80FF_017F;
    pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    foreach (pats[p])
      for (int c = 0; c < 16; c++)
        one_load(pats[p], c[1:0], c[2], c[3]);
  endtask

  task automatic t_sign_edges;
    one_load(64'h0000_0000_0000_0080, 2'd0, 1'b1, 1'b0);
    check("R5", out_data, 64'hFFFF_FFFF_FFFF_FF80);
    one_load(64'h0000_0000_0000_7F80, 2'd1, 1'b1, 1'b0);
    check("R5", out_data, 64'hFFFF_FFFF_FFFF_807F);
    one_load(64'h0000_0000_0000_807F, 2'd1, 1'b1, 1'b0);
    check("R5", out_data, 64'h0000_0000_0000_7F80);
    one_load(64'hFFFF_FFFF_4433_2211, 2'd2, 1'b1, 1'b0);
    check("R5", out_data, 64'h0000_0000_1122_3344);
  endtask

  task automatic t_reverse_fixed;
    one_load(64'hDEAD_BEEF_CAFE_1234, 2'd1, 1'b0, 1'b1);
    check("R6", out_data, 64'h0000_0000_0000_1234);
    one_load(64'hDEAD_BEEF_CAFE_1234, 2'd2, 1'b0, 1'b1);
    check("R7", out_data, 64'h0000_0000_CAFE_1234);
    one_load(64'h0807_0605_0403_0201, 2'd3, 1'b0, 1'b1);
    check("R8", out_data, 64'h0807_0605_0403_0201);
    one_load(64'h0807_0605_0403_0201, 2'd3, 1'b0, 1'b0);
    check("R8", out_data, 64'h0102_0304_0506_0708);
    one_load(64'h0807_0605_0403_0281, 2'd3, 1'b1, 1'b0);
    check("R9", out_data, 64'h8102_0304_0506_0708);
  endtask

  task automatic t_noise_above;
    one_load(64'hA5A5_A5A5_A5A5_A512, 2'd0, 1'b0, 1'b1);
    check("R12", out_data, 64'h0000_0000_0000_0012);
    one_load(64'hFFFF_FFFF_FFFF_3412, 2'd1, 1'b0, 1'b0);
    check("R12", out_data, 64'h0000_0000_0000_1234);
  endtask

  task automatic t_error_dbl;
    one_load(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 1'b1);
    check("R10", {63'd0, out_err}, 64'd1);
    check("R10", out_data, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] seen;
    one_load(64'h1122_3344_5566_7788, 2'd2, 1'b0, 1'b0);
    seen = out_data;
    in_data = 64'hFFFF_FFFF_FFFF_FFFF; in_sext = 1'b1; in_brev = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11", out_data, seen);
      check("R11", {62'd0, out_valid, out_err}, 64'd0);
    end
    in_sext = 1'b0; in_brev = 1'b0;
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    drive(64'h0000_0000_0000_00F0, 2'd0, 1'b1, 1'b0);
    @(negedge clk);
    check("R2", out_data, 64'hFFFF_FFFF_FFFF_FFF0);
    drive(64'h0000_0000_0000_ABCD, 2'd1, 1'b0, 1'b1);
    @(negedge clk);
    check("R2", out_data, 64'h0000_0000_0000_ABCD);
    check("R2", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_modes();
    t_sign_edges();
    t_reverse_fixed();
    t_noise_above();
    t_error_dbl();
    t_hold();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule